// File: doc/BRIEF.md
# CAN Controller Low-Power Mode Sequencer

This block chooses the operating mode of a CAN protocol engine. It combines the processor's run, wait or stop state with a clock-stop-in-wait control bit, a soft-reset control bit and the sleep-acknowledge state it keeps itself. From these it produces one of four modes: normal, sleep, soft-reset or power-down.

It also serves the processor's sleep request. Sleep is not granted while work is still in flight. Every transmit buffer must first report empty, whether its frame was sent or aborted. A frame seen arriving must be followed by the bus being reported idle. When nothing is in flight, sleep is granted at the next clock edge.

Both outputs are registered. The mode output and the sleep-acknowledge bit move together on the same rising edge.

Top module: `can_pwr_mode_seq`

## Requirements
- R1: With the CPU mode input at 2'b10 (stop) or 2'b11 (also treated as stop), the mode output becomes 2'b11 (power-down) at the next rising edge. This holds whatever the clock-stop, soft-reset and sleep-acknowledge values are.
- R2: With the CPU mode input at 2'b01 (wait) and the clock-stop-in-wait bit at 1, the mode output becomes 2'b11 at the next edge.
- R3: With the CPU mode at 2'b00 (run), or at 2'b01 with clock-stop at 0, the mode output is decoded as follows: 2'b01 (sleep) when sleep-acknowledge is 1; 2'b10 (soft-reset) when soft-reset is 1; otherwise 2'b00 (normal).
- R4: In run mode, the clock-stop-in-wait bit has no effect on the mode output.
- R5: While any transmit-empty flag is 0, sleep-acknowledge stays 0 under a sleep request. It rises at the edge after the cycle in which all flags read 1.
- R6: If a reception was seen while sleep was requested, sleep-acknowledge rises at the edge after the first cycle with bus-idle at 1. This holds even if receive-active has already dropped.
- R7: With all buffers empty, no reception and sleep requested, sleep-acknowledge and mode 2'b01 appear at the next edge.
- R8: Once the sleep request is cleared, sleep-acknowledge falls at the next edge and the mode returns to 2'b00.
- R9: Soft-reset overrides a pending or granted sleep request. At the next edge it clears sleep-acknowledge, and the mode is 2'b10 unless power-down applies.
- R10: While waiting for sleep, a buffer newly marked pending (its flag going 0) keeps sleep-acknowledge low until all flags are 1 again.
- R11: A synchronous active-low reset sets the mode to 2'b00 and sleep-acknowledge to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous active-low reset |
| cpuMode | input | 2 | 00 run, 01 wait, 10/11 stop |
| clkStopInWait | input | 1 | Stop the engine clock while the CPU waits |
| softRst | input | 1 | Soft-reset control |
| sleepReq | input | 1 | Sleep request from the CPU |
| txEmpty | input | NUM_TX (3) | Per-buffer empty flags, 0 = frame scheduled |
| rxActive | input | 1 | A frame is being received |
| busIdle | input | 1 | The bus is idle |
| sleepAck | output | 1 | Sleep granted |
| modeOut | output | 2 | 00 normal, 01 sleep, 10 soft-reset, 11 power-down |

## Verification
Soft-reset and sleep entry can fall in the same cycle. This happens when soft-reset is raised in exactly the cycle that the last pending transmit buffer reports empty. The bench sets up exactly that case and expects mode 2'b10 with acknowledge low at the next edge. It then expects sleep to be granted one edge after soft-reset is released, because the request is still standing. A second collision, stop mode arriving while sleep is granted, is judged by power-down winning the mode output while the acknowledge stays high.

// File: rtl/can_pwr_pkg.sv
package can_pwr_pkg;
  typedef enum logic [1:0] {
    CPU_RUN  = 2'b00,
    CPU_WAIT = 2'b01,
    CPU_STOP = 2'b10,
    CPU_HALT = 2'b11
  } cpuMode_e;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'b00,
    MODE_SLEEP   = 2'b01,
    MODE_SOFTRST = 2'b10,
    MODE_PWRDN   = 2'b11
  } linkMode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic setAck;
    logic dropAck;
    logic trackRx;
    logic clearRx;
  } seqStrobe_t;
endpackage

// File: rtl/can_pwr_ctrl.sv
module can_pwr_ctrl
  import can_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sleepReq,
  input  logic       softRst,
  input  logic       wakeReady,
  input  logic       sleepAck,
  output seqStrobe_t strb
);
  typedef enum logic [1:0] {S_IDLE, S_DRAIN, S_ASLEEP} seqState_e;
  seqState_e stateQ, stateNext;

  always_comb begin
    strb      = '0;
    stateNext = stateQ;
    if (softRst) begin
      strb.dropAck = 1'b1;
      strb.clearRx = 1'b1;
      stateNext    = S_IDLE;
    end else begin
      unique case (stateQ)
        S_IDLE: if (sleepReq) begin
          if (wakeReady) begin
            strb.setAck  = 1'b1;
            strb.clearRx = 1'b1;
            stateNext    = S_ASLEEP;
          end else begin
            strb.trackRx = 1'b1;
            stateNext    = S_DRAIN;
          end
        end
        S_DRAIN: begin
          if (!sleepReq) begin
            strb.clearRx = 1'b1;
            stateNext    = S_IDLE;
          end else if (wakeReady) begin
            strb.setAck  = 1'b1;
            strb.clearRx = 1'b1;
            stateNext    = S_ASLEEP;
          end else begin
            strb.trackRx = 1'b1;
          end
        end
        S_ASLEEP: if (!sleepReq) begin
          strb.dropAck = 1'b1;
          stateNext    = S_IDLE;
        end
        default: stateNext = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= S_IDLE;
    else       stateQ <= stateNext;
  end

  // R8: acknowledge falls one edge after the request is withdrawn
  a_r8_ack_drop: assert property (@(posedge clk) disable iff (!rstN)
    (sleepAck && !sleepReq) |=> !sleepAck);

  // R7: no grant without a standing request
  a_r7_no_grant_unasked: assert property (@(posedge clk) disable iff (!rstN)
    !sleepReq |=> !$rose(sleepAck));
endmodule

// File: rtl/can_pwr_dp.sv
module can_pwr_dp
  import can_pwr_pkg::*;
#(
  parameter int NUM_TX = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cpuMode,
  input  logic              clkStopInWait,
  input  logic              softRst,
  input  logic [NUM_TX-1:0] txEmpty,
  input  logic              rxActive,
  input  logic              busIdle,
  input  seqStrobe_t        strb,
  output logic              wakeReady,
  output logic              sleepAck,
  output logic [1:0]        modeOut
);
  logic      ackQ, ackNext, rxSeenQ, txAllEmpty, rxBusy, pwrDown;
  linkMode_e modeQ, modeNext;

  assign txAllEmpty = &txEmpty;
  assign rxBusy     = rxActive | rxSeenQ;
  assign wakeReady  = txAllEmpty && (!rxBusy || busIdle);

  always_comb begin
    if (strb.setAck)       ackNext = 1'b1;
    else if (strb.dropAck) ackNext = 1'b0;
    else                   ackNext = ackQ;
  end

  assign pwrDown = cpuMode[1] || (cpuMode == CPU_WAIT && clkStopInWait);

  always_comb begin
    if (pwrDown)      modeNext = MODE_PWRDN;
    else if (softRst) modeNext = MODE_SOFTRST;
    else if (ackNext) modeNext = MODE_SLEEP;
    else              modeNext = MODE_NORMAL;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ackQ    <= 1'b0;
      modeQ   <= MODE_NORMAL;
      rxSeenQ <= 1'b0;
    end else begin
      ackQ  <= ackNext;
      modeQ <= modeNext;
      if (strb.clearRx)                  rxSeenQ <= 1'b0;
      else if (strb.trackRx && rxActive) rxSeenQ <= 1'b1;
    end
  end

  assign sleepAck = ackQ;
  assign modeOut  = modeQ;

  // R1: stop forces power-down
  a_r1_stop_pwrdn: assert property (@(posedge clk) disable iff (!rstN)
    cpuMode[1] |=> modeOut == MODE_PWRDN);

  // R2: wait with clock stop forces power-down
  a_r2_wait_clkstop: assert property (@(posedge clk) disable iff (!rstN)
    (cpuMode == CPU_WAIT && clkStopInWait) |=> modeOut == MODE_PWRDN);

  // R9: soft-reset wins over sleep
  a_r9_softrst_wins: assert property (@(posedge clk) disable iff (!rstN)
    (softRst && cpuMode == CPU_RUN) |=> (modeOut == MODE_SOFTRST && !sleepAck));

  // R5: a grant only follows a cycle with every buffer empty
  a_r5_tx_drained: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sleepAck) |-> $past(txAllEmpty));
endmodule

// File: rtl/can_pwr_mode_seq.sv
module can_pwr_mode_seq
  import can_pwr_pkg::*;
#(
  parameter int NUM_TX = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cpuMode,
  input  logic              clkStopInWait,
  input  logic              softRst,
  input  logic              sleepReq,
  input  logic [NUM_TX-1:0] txEmpty,
  input  logic              rxActive,
  input  logic              busIdle,
  output logic              sleepAck,
  output logic [1:0]        modeOut
);
  seqStrobe_t strb;
  logic       wakeReady;

  can_pwr_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sleepReq  (sleepReq),
    .softRst   (softRst),
    .wakeReady (wakeReady),
    .sleepAck  (sleepAck),
    .strb      (strb)
  );

  can_pwr_dp #(.NUM_TX(NUM_TX)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .cpuMode       (cpuMode),
    .clkStopInWait (clkStopInWait),
    .softRst       (softRst),
    .txEmpty       (txEmpty),
    .rxActive      (rxActive),
    .busIdle       (busIdle),
    .strb          (strb),
    .wakeReady     (wakeReady),
    .sleepAck      (sleepAck),
    .modeOut       (modeOut)
  );
endmodule

// File: tb/can_pwr_mode_seq_bench.sv
module can_pwr_mode_seq_bench;
  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] cpuMode;
  logic       clkStopInWait, softRst, sleepReq, rxActive, busIdle;
  logic [2:0] txEmpty;
  logic       sleepAck;
  logic [1:0] modeOut;
  int         nChecks = 0;
  int         nFails  = 0;

  always #5 clk = ~clk;

  can_pwr_mode_seq u_can_pwr_mode_seq (
    .clk(clk), .rstN(rstN), .cpuMode(cpuMode), .clkStopInWait(clkStopInWait),
    .softRst(softRst), .sleepReq(sleepReq), .txEmpty(txEmpty),
    .rxActive(rxActive), .busIdle(busIdle), .sleepAck(sleepAck), .modeOut(modeOut)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [1:0] expMode, input logic expAck);
    nChecks++;
    if (modeOut !== expMode || sleepAck !== expAck) begin
      nFails++;
      $display("FAIL %s: mode=%b ack=%b expected mode=%b ack=%b",
               req, modeOut, sleepAck, expMode, expAck);
    end
  endtask

  task automatic quiet();
    cpuMode = 2'b00; clkStopInWait = 1'b0; softRst = 1'b0; sleepReq = 1'b0;
    txEmpty = 3'b111; rxActive = 1'b0; busIdle = 1'b1;
  endtask

  task automatic t_reset();  // R11
    quiet();
    rstN = 1'b0;
    repeat (3) tick();
    chk("R11 reset", 2'b00, 1'b0);
    rstN = 1'b1;
    tick();
    chk("R11 after reset", 2'b00, 1'b0);
  endtask

  task automatic t_power();  // R1 R2 R4
    cpuMode = 2'b10; softRst = 1'b1; clkStopInWait = 1'b1; tick();
    chk("R1 stop", 2'b11, 1'b0);
    cpuMode = 2'b11; softRst = 1'b0; clkStopInWait = 1'b0; tick();
    chk("R1 stop alt", 2'b11, 1'b0);
    cpuMode = 2'b01; clkStopInWait = 1'b1; tick();
    chk("R2 wait clkstop", 2'b11, 1'b0);
    clkStopInWait = 1'b0; tick();
    chk("R3 wait running", 2'b00, 1'b0);
    cpuMode = 2'b00; clkStopInWait = 1'b1; tick();
    chk("R4 run ignores clkstop", 2'b00, 1'b0);
    quiet(); tick();
  endtask

  task automatic t_softrst();  // R3 R9
    softRst = 1'b1; tick();
    chk("R3 softrst decode", 2'b10, 1'b0);
    softRst = 1'b0; tick();
    chk("R3 normal decode", 2'b00, 1'b0);
  endtask

  task automatic t_idle_sleep();  // R7 R8 R3
    sleepReq = 1'b1; tick();
    chk("R7 immediate sleep", 2'b01, 1'b1);
    cpuMode = 2'b10; tick();
    chk("R1 stop while asleep", 2'b11, 1'b1);
    cpuMode = 2'b00; tick();
    chk("R3 sleep decode", 2'b01, 1'b1);
    sleepReq = 1'b0; tick();
    chk("R8 wake", 2'b00, 1'b0);
    cpuMode = 2'b01; sleepReq = 1'b1; tick();
    chk("R3 sleep in wait", 2'b01, 1'b1);
    quiet(); tick();
  endtask

  task automatic t_tx_drain();  // R5
    txEmpty = 3'b101; sleepReq = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R5 deferred by tx", 2'b00, 1'b0);
    end
    txEmpty = 3'b111; tick();
    chk("R5 drained", 2'b01, 1'b1);
    quiet(); tick();
  endtask

  task automatic t_tx_restart();  // R10
    txEmpty = 3'b110; sleepReq = 1'b1; tick();
    chk("R10 waiting", 2'b00, 1'b0);
    txEmpty = 3'b101; tick();
    chk("R10 new pending", 2'b00, 1'b0);
    tick();
    chk("R10 still waiting", 2'b00, 1'b0);
    txEmpty = 3'b111; tick();
    chk("R10 drained", 2'b01, 1'b1);
    quiet(); tick();
  endtask

  task automatic t_rx();  // R6
    rxActive = 1'b1; busIdle = 1'b0; sleepReq = 1'b1;
    tick(); tick();
    chk("R6 receiving", 2'b00, 1'b0);
    rxActive = 1'b0; tick();
    chk("R6 bus not idle yet", 2'b00, 1'b0);
    busIdle = 1'b1; tick();
    chk("R6 bus idle", 2'b01, 1'b1);
    quiet(); tick();
  endtask

  task automatic t_collide();  // R9 collisions
    txEmpty = 3'b011; sleepReq = 1'b1; tick();
    chk("R9 pending", 2'b00, 1'b0);
    txEmpty = 3'b111; softRst = 1'b1; tick();
    chk("R9 softrst at drain", 2'b10, 1'b0);
    softRst = 1'b0; tick();
    chk("R9 regrant", 2'b01, 1'b1);
    softRst = 1'b1; tick();
    chk("R9 clears grant", 2'b10, 1'b0);
    quiet(); tick();
    chk("R8 quiet", 2'b00, 1'b0);
  endtask

  initial begin
    t_reset();
    t_power();
    t_softrst();
    t_idle_sleep();
    t_tx_drain();
    t_tx_restart();
    t_rx();
    t_collide();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #2000000;
    nChecks++;
    nFails++;
    $display("FAIL R11 watchdog: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule